// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives an active-low reset line for a processor. Three events pull the line low: the end of power-on, a supply that has dropped below a chosen voltage level, and a watchdog that was not serviced in time. Each time the line goes low it stays low for a fixed hold time, counted in ticks of a slow timebase. The default timebase is a 1 kHz tick with a 100-tick hold, which gives 100 ms. The analog supply comparison happens outside the block. The block receives one digital "below threshold" flag for each of four levels, uses the level that software has selected, and also takes a flag for a weak backup supply.

Software reaches the block through three small registers. A status register reports which events have happened since they were last cleared. Writing a fixed 4-bit key to the low nibble of that same register restarts the watchdog. A watchdog register holds an enable bit and a 5-bit timeout code, where the timeout equals the code times 100 ms. A threshold register selects the voltage level. There is no streaming data path: every pin is a plain control or status pin. Register writes take effect in the same cycle, and reads are combinational on the select input.

Top module: `rst_supervisor`

## Requirements
- R1: When `por_n` is released, `rst_out_n` stays low until the HOLD_TICKS-th tick that follows. It then rises on the clock edge of that tick. The power-on flag reads 1 after power-on.
- R2: When the selected level flag `lv_below[thr]` is 1, `rst_out_n` is low from the next clock edge. It stays low while the flag stays 1 and rises HOLD_TICKS ticks after the flag clears. The other three level flags have no effect on `rst_out_n`.
- R3: Select 2 holds the threshold in bits [1:0], and these bits read back as written. They reset to 0.
- R4: Select 1 holds the watchdog enable in bit 7 and the timeout code in bits [4:0], reset 0. The watchdog expires on the code×STEP_TICKS-th tick after it starts counting. It never expires if the enable bit is 0 or the code is 0.
- R5: An expiry drives `rst_out_n` low on that tick's edge for HOLD_TICKS ticks and sets the watchdog flag, status bit 7.
- R6: A write to select 0 with bits [3:0] = 1010 restarts the watchdog count. Any other value in bits [3:0] leaves the count unchanged.
- R7: The watchdog count is held at zero while reset is active or the selected low-voltage flag is 1. After a reset ends, the next expiry therefore needs a full timeout.
- R8: Status flags are bit 7 watchdog, bit 6 power-on, bit 5 low-voltage and bit 4 backup. Each flag stays set until software writes 1 to its bit. If a flag is set and cleared in the same cycle, the set wins.
- R9: `bkp_low` = 1 sets the backup flag and does not affect `rst_out_n`.
- R10: A restart write that lands on the clock edge of the expiring tick wins. No reset occurs, and a full timeout starts again from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tick_1k | input | 1 | One-cycle timebase pulse |
| lv_below | input | NUM_LEVELS | Below-threshold flag for each voltage level |
| bkp_low | input | 1 | Backup supply is weak |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status/restart, 1 watchdog, 2 threshold |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| rst_out_n | output | 1 | Stretched reset, active low |

## Verification
Two functions can land on one clock edge: a restart write from software and the timer reaching its limit on a tick. The bench counts tick edges from the moment the watchdog is enabled. It drives the key write so that the write is sampled on exactly the edge of the expiring tick. The check is that reset stays high and that the next expiry arrives a full timeout after that edge. A second check sweeps every non-key nibble and confirms that none of them moves the expiry point.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_WDOG = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam logic [3:0] KICK_KEY = 4'b1010;
  localparam int CODE_W = 5;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  // status bit positions
  localparam int ST_WD  = 7;
  localparam int ST_POR = 6;
  localparam int ST_LV  = 5;
  localparam int ST_BKP = 4;
endpackage

// File: rtl/rstsup_regs.sv
module rstsup_regs
  import rstsup_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int TW = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              wd_fire,
  input  logic              lv_now,
  input  logic              bkp_low,
  output logic              wd_en,
  output logic [CODE_W-1:0] wd_code,
  output logic [TW-1:0]     thr_sel,
  output logic              kick
);
  sel_e sel;
  logic wr_stat, wr_wdog, wr_thr;
  logic [3:0] flags, flag_set, flag_clr;

  assign sel     = sel_e'(reg_sel);
  assign wr_stat = wr_en && (sel == SEL_STAT);
  assign wr_wdog = wr_en && (sel == SEL_WDOG);
  assign wr_thr  = wr_en && (sel == SEL_THR);
  assign kick    = wr_stat && (wr_data[3:0] == KICK_KEY);

  // flags[3]=wd, [2]=por, [1]=lv, [0]=bkp
  assign flag_set = {wd_fire, 1'b0, lv_now, bkp_low};
  assign flag_clr = wr_stat ? wr_data[7:4] : 4'b0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags   <= 4'b0100;
      wd_en   <= 1'b0;
      wd_code <= '0;
      thr_sel <= '0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (wr_wdog) begin
        wd_en   <= wr_data[7];
        wd_code <= wr_data[CODE_W-1:0];
      end
      if (wr_thr) thr_sel <= wr_data[TW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (sel)
      SEL_STAT: rd_data[7:4] = flags;
      SEL_WDOG: begin
        rd_data[7]          = wd_en;
        rd_data[CODE_W-1:0] = wd_code;
      end
      SEL_THR:  rd_data[TW-1:0] = thr_sel;
      default:  rd_data = '0;
    endcase
  end

  // R8
  wd_flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(flags[3]) |-> $past(wr_stat && wr_data[ST_WD]));
  // R9
  bkp_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    bkp_low |=> flags[0]);
  // R5
  wd_flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> flags[3]);
endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
  import rstsup_pkg::*;
#(
  parameter int STEP_TICKS = 100,
  localparam int CW = $clog2(MAX_CODE * STEP_TICKS + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              tick,
  input  logic              wd_en,
  input  logic [CODE_W-1:0] wd_code,
  input  logic              hold,
  input  logic              kick,
  output logic              fire
);
  logic [CW-1:0] cnt, limit;
  logic run;

  assign limit = CW'(wd_code) * CW'(STEP_TICKS);
  assign run   = wd_en && (wd_code != '0) && !hold;
  assign fire  = run && tick && !kick && (cnt >= limit - CW'(1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt <= '0;
    else if (!run || kick || fire) cnt <= '0;
    else if (tick)              cnt <= cnt + CW'(1);
  end

  // R4
  fire_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    fire |-> (wd_en && wd_code != '0 && !hold));
  // R7
  hold_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold |=> (cnt == '0));
  // R6
  kick_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    kick |=> (cnt == '0));
endmodule

// File: rtl/rstsup_hold.sv
module rstsup_hold #(
  parameter int HOLD_TICKS = 100,
  localparam int HW = $clog2(HOLD_TICKS + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic lv_now,
  input  logic wd_fire,
  output logic active
);
  logic [HW-1:0] left;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active <= 1'b1;
      left   <= HW'(HOLD_TICKS);
    end else if (lv_now || wd_fire) begin
      active <= 1'b1;
      left   <= HW'(HOLD_TICKS);
    end else if (active && tick) begin
      if (left == HW'(1)) active <= 1'b0;
      left <= left - HW'(1);
    end
  end

  // R2
  lv_assert_chk: assert property (@(posedge clk) disable iff (!por_n)
    lv_now |=> active);
  // R5
  wd_assert_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> active);
  // R1
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> $past(tick));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rstsup_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int STEP_TICKS = 100,
  parameter int HOLD_TICKS = 100
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  tick_1k,
  input  logic [NUM_LEVELS-1:0] lv_below,
  input  logic                  bkp_low,
  input  logic                  wr_en,
  input  logic [1:0]            reg_sel,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic                  rst_out_n
);
  localparam int TW = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  logic              wd_en, kick, fire, active, lv_now;
  logic [CODE_W-1:0] wd_code;
  logic [TW-1:0]     thr_sel;

  assign lv_now    = lv_below[thr_sel];
  assign rst_out_n = !active;

  rstsup_regs #(.NUM_LEVELS(NUM_LEVELS)) u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .wd_fire(fire), .lv_now(lv_now),
    .bkp_low(bkp_low), .wd_en(wd_en), .wd_code(wd_code), .thr_sel(thr_sel),
    .kick(kick)
  );

  rstsup_wdog #(.STEP_TICKS(STEP_TICKS)) u_wdog (
    .clk(clk), .por_n(por_n), .tick(tick_1k), .wd_en(wd_en),
    .wd_code(wd_code), .hold(active || lv_now), .kick(kick), .fire(fire)
  );

  rstsup_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .por_n(por_n), .tick(tick_1k), .lv_now(lv_now),
    .wd_fire(fire), .active(active)
  );

  // R9
  bkp_no_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bkp_low && !lv_now && !fire && rst_out_n) |=> rst_out_n);
endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int STEP = 4;
  localparam int HOLD = 5;
  localparam int TPS  = 4;

  logic clk = 0, por_n = 0, bkp_low = 0, wr_en = 0;
  logic [3:0] lv_below = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic rst_out_n;
  int cyc = 0;
  logic tick_1k;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tick_1k = (cyc % TPS) == TPS - 1;

  rst_supervisor #(.NUM_LEVELS(4), .STEP_TICKS(STEP), .HOLD_TICKS(HOLD)) uut (
    .clk(clk), .por_n(por_n), .tick_1k(tick_1k), .lv_below(lv_below),
    .bkp_low(bkp_low), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .rst_out_n(rst_out_n)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    reg_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] s, output logic [7:0] d);
    reg_sel = s; #1; d = rd_data;
  endtask

  task automatic wait_ticks(int n);
    int k = 0;
    while (k < n) begin
      logic tk = tick_1k;
      @(negedge clk);
      if (tk) k++;
    end
  endtask

  task automatic measure(logic lvl, output int n);
    n = 0;
    for (int i = 0; i < 4000; i++) begin
      logic tk;
      if (rst_out_n == lvl) return;
      tk = tick_1k;
      @(negedge clk);
      if (tk) n++;
    end
    n = -1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset low during por", rst_out_n, 0);
    rd(2'd1, d); check("R4 wdog reg reset", d, 0);
    rd(2'd2, d); check("R3 thr reg reset", d, 0);
    por_n = 1;
    measure(1, n); check("R1 por hold ticks", n, HOLD);
    rd(2'd0, d); check("R1 R8 por flag", d, 8'h40);
    wr(2'd0, 8'h40);
    rd(2'd0, d); check("R8 por flag cleared", d, 0);

    // R2/R3 sweep: every threshold x every level line
    for (int t = 0; t < 4; t++) begin
      wr(2'd2, 8'(t));
      rd(2'd2, d); check("R3 thr readback", d, t);
      for (int j = 0; j < 4; j++) begin
        lv_below = 4'(1 << j);
        @(negedge clk);
        check("R2 level select", rst_out_n, (j == t) ? 0 : 1);
        wait_ticks(3);
        check("R2 held while low", rst_out_n, (j == t) ? 0 : 1);
        lv_below = 0;
        if (j == t) begin
          measure(1, n); check("R2 hold after clear", n, HOLD);
          rd(2'd0, d); check("R2 R8 lowv flag", d, 8'h20);
          wr(2'd0, 8'h20);
        end else begin
          rd(2'd0, d); check("R2 ignored line no flag", d, 0);
        end
      end
    end
    wr(2'd2, 8'd0);

    // R4 disabled cases
    wr(2'd1, 8'h05);
    rd(2'd1, d); check("R4 wdog readback", d, 8'h05);
    wait_ticks(40); check("R4 enable off never fires", rst_out_n, 1);
    wr(2'd1, 8'h80);
    wait_ticks(40); check("R4 code 0 never fires", rst_out_n, 1);

    // R4/R5 timeout sweep
    for (int c = 1; c <= 31; c += (c < 6) ? 1 : 25) begin
      wr(2'd1, 8'h00);
      wr(2'd1, 8'h80 | 8'(c));
      measure(0, n); check("R4 timeout ticks", n, c * STEP);
      measure(1, n); check("R5 wd hold ticks", n, HOLD);
      wr(2'd1, 8'h00);
      rd(2'd0, d); check("R5 wd flag", d, 8'h80);
      wr(2'd0, 8'h80);
      rd(2'd0, d); check("R8 wd flag cleared", d, 0);
    end

    // R6 bad keys have no effect
    for (int k = 0; k < 16; k++) begin
      wr(2'd1, 8'h00);
      wr(2'd1, 8'h82);
      wait_ticks(4);
      wr(2'd0, 8'(k));
      measure(0, n);
      check("R6 key effect", n, (k == 10) ? 2 * STEP : STEP * 2 - 4);
      measure(1, n);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h80);
    end

    // R6 repeated good kicks keep reset high
    wr(2'd1, 8'h82);
    for (int r = 0; r < 6; r++) begin
      wait_ticks(5);
      wr(2'd0, 8'h0A);
    end
    check("R6 serviced no reset", rst_out_n, 1);
    rd(2'd0, d); check("R6 serviced no flag", d, 0);
    wr(2'd1, 8'h00);

    // R10 kick on the expiring tick edge
    wr(2'd1, 8'h82);
    begin
      int m = 0;
      while (1) begin
        if (tick_1k) begin
          if (m == 2 * STEP - 1) break;
          m++;
        end
        @(negedge clk);
      end
    end
    wr(2'd0, 8'h0A);
    check("R10 kick wins same edge", rst_out_n, 1);
    measure(0, n); check("R10 full timeout after kick", n, 2 * STEP);
    measure(1, n);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h80);

    // R7 counter held during low voltage
    wr(2'd1, 8'h82);
    wait_ticks(5);
    lv_below = 4'b0001;
    wait_ticks(2);
    lv_below = 0;
    measure(1, n); check("R7 lv hold", n, HOLD);
    measure(0, n); check("R7 fresh timeout after lv", n, 2 * STEP);
    measure(1, n);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hF0);

    // R9 backup flag
    bkp_low = 1;
    repeat (3) @(negedge clk);
    check("R9 backup no reset", rst_out_n, 1);
    bkp_low = 0;
    @(negedge clk);
    rd(2'd0, d); check("R9 backup flag", d, 8'h10);
    wr(2'd0, 8'h10);
    rd(2'd0, d); check("R8 backup cleared", d, 0);

    done = 1;
    summary();
  end
endmodule